// File: doc/BRIEF.md
# SMBus Register Slave with Block Transfers

This block is a two-wire bus slave that gives a host access to a 128-entry byte register file. It oversamples SCL and SDA with the system clock and finds start, repeated-start and stop conditions. It shifts bytes in and out, and it drives SDA only through an open-drain enable. Each write transaction loads an 8-bit pointer register. The low seven bits of the pointer select a register. The top bit selects either a single-byte access or a block access.

The block handles five transaction types: send byte, write byte, block write, receive byte, and block read. A block read uses a pointer write, a repeated start and a read. The slave first returns a byte count, taken from register 0, and then returns that many registers at ascending indices. Register 1 holds the bus-timeout enables. Both registers reset to zero, so the timeout is off after reset.

Each stored byte also appears for one cycle on a registered write port. The 7-bit bus address comes from a strap input.

Top module: `smb_reg_slave`

## Requirements
- R1: A byte received after a start is acknowledged only if its upper seven bits equal `dev_addr`. On a mismatch the slave does not acknowledge and ignores all traffic until the next start.
- R2: In a write transaction, the first byte after the address byte is stored as the pointer. A send byte (pointer only) changes no register.
- R3: If pointer bit 7 is 0, the next data byte is stored at index pointer[6:0]. Any further bytes in the same transaction are acknowledged but not stored.
- R4: A read transaction with pointer bit 7 = 0 returns the register at pointer[6:0]. The pointer does not advance.
- R5: If pointer bit 7 is 1, the next written byte is a count, clamped to 32. Up to that many data bytes are stored at consecutive indices starting at pointer[6:0]. Bytes beyond the count are acknowledged but not stored.
- R6: A read transaction with pointer bit 7 = 1 first returns min(register 0, 32). It then returns the registers at consecutive indices starting at pointer[6:0].
- R7: After the master NACKs a byte, the slave releases SDA until the next start.
- R8: The timeout is off after reset (register 1 = 0). A stalled bus then leaves the slave's SDA drive unchanged.
- R9: If register 1 bit 4 is set, a busy slave that sees no SCL edge for `TIMEOUT_CYC` clocks releases SDA and goes idle. Bit 5 does the same, but only while the slave is pulling SDA low.
- R10: A stop condition returns the slave to idle with SDA released.
- R11: Every stored byte produces a one-cycle `rf_we` pulse carrying its index and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| dev_addr | input | 7 | Strapped 7-bit bus address |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| rf_we | output | 1 | One-cycle strobe for a stored byte |
| rf_idx | output | 7 | Register index of the stored byte |
| rf_wdata | output | 8 | Data of the stored byte |

## Verification
The assertions assume that each SCL phase lasts well over three system clocks. They also assume that the master changes SDA only while SCL is low, except when it forms a start or a stop. The bench's bit-banged master meets both assumptions: it holds each SCL phase for ten clocks and moves SDA two clocks after each falling edge. Random pointers and lengths are chosen so that block transfers never wrap into registers 0 and 1. This keeps the timeout enables in a known state, and only the directed cases write those two registers.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RXACK, ST_TX, ST_TXACK, ST_SKIP
  } smb_state_e;

  typedef enum logic [1:0] {
    RL_ADDR, RL_PTR, RL_CNT, RL_DATA
  } rx_role_e;
endpackage

// File: rtl/smb_cond.sv
module smb_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [SYNC_STAGES-1:0] scl_sr, sda_sr;
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[SYNC_STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[SYNC_STAGES-2:0], sda_i};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end
  end

  assign scl_s     = scl_sr[SYNC_STAGES-1];
  assign sda_s     = sda_sr[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
  parameter int IDX_W = 7,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [DW-1:0]    rdata
);
  localparam int DEPTH = 1 << IDX_W;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/smb_timeout.sv
module smb_timeout #(
  parameter int LIMIT = 2500000
) (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  input  logic activity,
  input  logic arm,
  output logic fire
);
  localparam int CW = $clog2(LIMIT) + 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !busy || activity) cnt <= '0;
    else if (cnt != LAST)         cnt <= cnt + 1'b1;
  end

  assign fire = arm && busy && !activity && (cnt == LAST);
endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave #(
  parameter int IDX_W       = 7,
  parameter int MAX_BLK     = 32,
  parameter int TIMEOUT_CYC = 2500000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [6:0]       dev_addr,
  output logic             sda_oe,
  output logic             rf_we,
  output logic [IDX_W-1:0] rf_idx,
  output logic [7:0]       rf_wdata
);
  import smb_pkg::*;

  localparam int CNT_W = $clog2(MAX_BLK + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_BLK);

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt, to_fire;

  smb_state_e       state;
  rx_role_e         role;
  logic [7:0]       sh, tx_sh, apr, blk_len_q, cfg_q, mem_q, rd_byte, tx_load;
  logic [3:0]       bitcnt;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] cnt_left, len_clamped;
  logic             single_done, tx_next, tx_is_cnt;

  smb_cond #(.SYNC_STAGES(2)) i_cond (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  smb_regfile #(.IDX_W(IDX_W), .DW(8)) i_rf (
    .clk(clk), .we(rf_we), .waddr(rf_idx), .wdata(rf_wdata),
    .raddr(idx), .rdata(mem_q)
  );

  smb_timeout #(.LIMIT(TIMEOUT_CYC)) i_to (
    .clk(clk), .rst(rst), .busy(state != ST_IDLE),
    .activity(scl_rise | scl_fall | start_evt | stop_evt),
    .arm(cfg_q[4] | (cfg_q[5] & sda_oe)), .fire(to_fire)
  );

  function automatic logic [CNT_W-1:0] clamp(input logic [7:0] v);
    return (v > 8'(MAX_BLK)) ? CNT_MAX : v[CNT_W-1:0];
  endfunction

  // registers 0 and 1 are served from their shadow copies
  always_comb begin
    len_clamped = clamp(blk_len_q);
    if (idx == '0)                  rd_byte = blk_len_q;
    else if (idx == IDX_W'(1))      rd_byte = cfg_q;
    else                            rd_byte = mem_q;
    tx_load = tx_is_cnt ? 8'(len_clamped) : rd_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_len_q <= '0;
      cfg_q     <= '0;
    end else if (rf_we) begin
      if (rf_idx == '0)             blk_len_q <= rf_wdata;
      else if (rf_idx == IDX_W'(1)) cfg_q     <= rf_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      role        <= RL_ADDR;
      sh          <= '0;
      tx_sh       <= '0;
      apr         <= '0;
      bitcnt      <= '0;
      idx         <= '0;
      cnt_left    <= '0;
      single_done <= 1'b0;
      tx_next     <= 1'b0;
      tx_is_cnt   <= 1'b0;
      sda_oe      <= 1'b0;
      rf_we       <= 1'b0;
      rf_idx      <= '0;
      rf_wdata    <= '0;
    end else begin
      rf_we <= 1'b0;
      if (to_fire) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_evt) begin
        state  <= ST_RX;
        role   <= RL_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_evt) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise && bitcnt != 4'd8) begin
              sh     <= {sh[6:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              state  <= ST_RXACK;
              sda_oe <= 1'b1;
              case (role)
                RL_ADDR: begin
                  if (sh[7:1] != dev_addr) begin
                    state  <= ST_SKIP;
                    sda_oe <= 1'b0;
                  end else if (sh[0]) begin
                    tx_next   <= 1'b1;
                    idx       <= apr[IDX_W-1:0];
                    tx_is_cnt <= apr[7];
                  end else begin
                    tx_next <= 1'b0;
                    role    <= RL_PTR;
                  end
                end
                RL_PTR: begin
                  apr         <= sh;
                  idx         <= sh[IDX_W-1:0];
                  single_done <= 1'b0;
                  role        <= sh[7] ? RL_CNT : RL_DATA;
                end
                RL_CNT: begin
                  cnt_left <= clamp(sh);
                  role     <= RL_DATA;
                end
                default: begin
                  if (apr[7]) begin
                    if (cnt_left != '0) begin
                      rf_we    <= 1'b1;
                      rf_idx   <= idx;
                      rf_wdata <= sh;
                      idx      <= idx + 1'b1;
                      cnt_left <= cnt_left - 1'b1;
                    end
                  end else if (!single_done) begin
                    rf_we       <= 1'b1;
                    rf_idx      <= idx;
                    rf_wdata    <= sh;
                    single_done <= 1'b1;
                  end
                end
              endcase
            end
          end
          ST_RXACK: begin
            if (scl_fall) begin
              if (tx_next) begin
                state  <= ST_TX;
                tx_sh  <= tx_load;
                sda_oe <= ~tx_load[7];
                bitcnt <= '0;
              end else begin
                state  <= ST_RX;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                sda_oe <= 1'b0;
                state  <= ST_TXACK;
                if (tx_is_cnt)   tx_is_cnt <= 1'b0;
                else if (apr[7]) idx <= idx + 1'b1;
              end else begin
                tx_sh  <= {tx_sh[6:0], 1'b0};
                sda_oe <= ~tx_sh[6];
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise && sda_s) begin
              state <= ST_SKIP;
            end else if (scl_fall) begin
              state  <= ST_TX;
              tx_sh  <= tx_load;
              sda_oe <= ~tx_load[7];
              bitcnt <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_reg_slave_chk.sv
module smb_reg_slave_chk #(
  parameter int CNT_W   = 6,
  parameter int MAX_BLK = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               scl_s,
  input logic               stop_evt,
  input logic               to_fire,
  input logic               sda_oe,
  input logic               rf_we,
  input smb_pkg::smb_state_e state,
  input logic [CNT_W-1:0]   cnt_left
);
  import smb_pkg::*;

  a_r1_drive_in_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);

  a_r10_stop_releases: assert property (@(posedge clk) disable iff (rst)
    stop_evt && !to_fire |=> !sda_oe && state == ST_IDLE);

  a_r9_timeout_releases: assert property (@(posedge clk) disable iff (rst)
    to_fire |=> !sda_oe && state == ST_IDLE);

  a_r11_store_in_ack: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> state == ST_RXACK);

  a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_left <= CNT_W'(MAX_BLK));
endmodule

bind smb_reg_slave smb_reg_slave_chk #(.CNT_W(CNT_W), .MAX_BLK(MAX_BLK)) i_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .stop_evt(stop_evt), .to_fire(to_fire),
  .sda_oe(sda_oe), .rf_we(rf_we), .state(state), .cnt_left(cnt_left)
);

// File: tb/test_smb_reg_slave.sv
module test_smb_reg_slave;
  localparam int HP  = 10;
  localparam int TO  = 300;
  localparam logic [6:0] DEV = 7'h2C;

  logic clk = 1'b0, rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, rf_we;
  logic [6:0] rf_idx;
  logic [7:0] rf_wdata;
  wire  sda_line = sda_m & ~sda_oe;

  int checks = 0, errors = 0, we_cnt = 0;
  logic [6:0] last_idx;
  logic [7:0] last_data;
  logic [7:0] mdl [128];
  logic [7:0] tx_buf [64];
  logic [7:0] rx_buf [64];

  always #5 clk = ~clk;

  smb_reg_slave #(.IDX_W(7), .MAX_BLK(32), .TIMEOUT_CYC(TO)) i_smb_reg_slave (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .dev_addr(DEV),
    .sda_oe(sda_oe), .rf_we(rf_we), .rf_idx(rf_idx), .rf_wdata(rf_wdata)
  );

  always @(negedge clk) if (rf_we) begin
    we_cnt++; last_idx = rf_idx; last_data = rf_wdata;
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    w(2); sda_m = 1'b1; w(HP-2); scl_m = 1'b1; w(HP); sda_m = 1'b0; w(HP); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    w(2); sda_m = 1'b0; w(HP-2); scl_m = 1'b1; w(HP); sda_m = 1'b1; w(HP);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      w(2); sda_m = b[i]; w(HP-2); scl_m = 1'b1; w(HP); scl_m = 1'b0;
    end
    w(2); sda_m = 1'b1; w(HP-2); scl_m = 1'b1; w(HP/2);
    ack = !sda_line; w(HP/2); scl_m = 1'b0;
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] b);
    w(2); sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      w(HP-2); scl_m = 1'b1; w(HP/2); b = {b[6:0], sda_line}; w(HP/2); scl_m = 1'b0; w(2);
    end
    sda_m = nack; w(HP-2); scl_m = 1'b1; w(HP); scl_m = 1'b0;
  endtask

  // write: tx_buf[0] is the pointer, n bytes after the address byte
  task automatic wr_txn(input logic [6:0] a, input int n, output bit all_ack);
    bit ack;
    bus_start();
    send_byte({a, 1'b0}, ack); all_ack = ack;
    for (int i = 0; i < n; i++) begin send_byte(tx_buf[i], ack); all_ack &= ack; end
    bus_stop();
  endtask

  task automatic rd_txn(input logic [7:0] ptr, input bit set_ptr, input int n);
    bit ack;
    logic [7:0] b;
    bus_start();
    if (set_ptr) begin
      send_byte({DEV, 1'b0}, ack); send_byte(ptr, ack); bus_start();
    end
    send_byte({DEV, 1'b1}, ack);
    for (int i = 0; i < n; i++) begin recv_byte(i == n-1, b); rx_buf[i] = b; end
    bus_stop();
  endtask

  task automatic wr1(input logic [7:0] idx, input logic [7:0] d);
    bit ok;
    tx_buf[0] = idx; tx_buf[1] = d; wr_txn(DEV, 2, ok);
    mdl[idx[6:0]] = d;
  endtask

  function automatic logic [7:0] clamp32(input logic [7:0] v);
    return (v > 8'd32) ? 8'd32 : v;
  endfunction

  initial begin
    bit ok;
    int base, len, p, n0;
    logic [7:0] b;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 128; i++) mdl[i] = 8'h00;
    w(5); rst = 1'b0; w(5);

    chk(sda_oe == 1'b0 && rf_we == 1'b0, "R10 reset idle", sda_oe, 0);

    // R3 / R11: write byte and strobe
    n0 = we_cnt;
    wr1(8'h23, 8'h5A);
    chk(we_cnt == n0 + 1 && last_idx == 7'h23 && last_data == 8'h5A, "R11 strobe", last_idx, 8'h23);
    chk(sda_oe == 1'b0, "R10 released after stop", sda_oe, 0);
    rd_txn(8'h23, 1'b1, 1);
    chk(rx_buf[0] == 8'h5A, "R4 read back", rx_buf[0], 8'h5A);

    // R2: send byte sets pointer only, receive byte uses it, no advance
    wr1(8'h24, 8'hC3);
    n0 = we_cnt;
    tx_buf[0] = 8'h23; wr_txn(DEV, 1, ok);
    chk(ok && we_cnt == n0, "R2 send byte no store", we_cnt - n0, 0);
    rd_txn(8'h00, 1'b0, 1);
    chk(rx_buf[0] == 8'h5A, "R2 pointer from send byte", rx_buf[0], 8'h5A);
    rd_txn(8'h00, 1'b0, 2);
    chk(rx_buf[1] == 8'h5A, "R4 no advance single", rx_buf[1], 8'h5A);

    // R3: extra bytes acked but not stored
    wr1(8'h11, 8'h77);
    n0 = we_cnt;
    tx_buf[0] = 8'h10; tx_buf[1] = 8'hA1; tx_buf[2] = 8'hB2; tx_buf[3] = 8'hC3;
    wr_txn(DEV, 4, ok); mdl[8'h10] = 8'hA1;
    chk(ok && we_cnt == n0 + 1, "R3 extra bytes acked one store", we_cnt - n0, 1);
    rd_txn(8'h11, 1'b1, 1);
    chk(rx_buf[0] == 8'h77, "R3 next reg untouched", rx_buf[0], 8'h77);

    // R1: wrong address not acked, ignored
    tx_buf[0] = 8'h10; tx_buf[1] = 8'hEE;
    wr_txn(DEV ^ 7'h01, 2, ok);
    chk(!ok, "R1 mismatch no ack", ok, 0);
    rd_txn(8'h10, 1'b1, 1);
    chk(rx_buf[0] == 8'hA1, "R1 mismatch ignored", rx_buf[0], 8'hA1);

    // R5: block write with count over the limit
    wr1(8'h60, 8'h3C); wr1(8'h61, 8'h4D);
    n0 = we_cnt;
    tx_buf[0] = 8'hC0; tx_buf[1] = 8'd40;
    for (int i = 0; i < 34; i++) tx_buf[2+i] = 8'(8'h90 + i);
    wr_txn(DEV, 36, ok);
    for (int i = 0; i < 32; i++) mdl[7'h40 + i] = 8'(8'h90 + i);
    chk(ok && we_cnt == n0 + 32, "R5 clamp 32 stores", we_cnt - n0, 32);
    rd_txn(8'h60, 1'b1, 1);
    chk(rx_buf[0] == 8'h3C, "R5 beyond count unchanged", rx_buf[0], 8'h3C);
    rd_txn(8'h5F, 1'b1, 1);
    chk(rx_buf[0] == 8'hAF, "R5 last block byte", rx_buf[0], 8'hAF);

    // R6: block read count clamps to 32
    wr1(8'h00, 8'd40);
    rd_txn(8'hC0, 1'b1, 33);
    chk(rx_buf[0] == 8'd32, "R6 count clamp", rx_buf[0], 32);
    chk(rx_buf[32] == mdl[7'h5F], "R6 32nd data", rx_buf[32], mdl[7'h5F]);

    // R7: after NACK the slave releases SDA
    bus_start(); send_byte({DEV, 1'b1}, ok); recv_byte(1'b1, b);
    w(HP);
    chk(sda_line == 1'b1, "R7 release after nack", sda_line, 1);
    scl_m = 1'b1; w(HP);
    chk(sda_line == 1'b1, "R7 still released", sda_line, 1);
    scl_m = 1'b0; bus_stop();

    // random mix
    for (int r = 0; r < 10; r++) begin
      base = 2 + int'($urandom % 100);
      len  = 1 + int'($urandom % 16);
      if ($urandom % 2 == 0) begin
        b = 8'($urandom);
        wr1(8'(base), b);
        rd_txn(8'(base), 1'b1, 1);
        chk(rx_buf[0] == mdl[base], "R4 random single", rx_buf[0], mdl[base]);
      end else begin
        tx_buf[0] = 8'(base) | 8'h80; tx_buf[1] = 8'(len);
        for (int i = 0; i < len; i++) begin
          tx_buf[2+i] = 8'($urandom); mdl[base+i] = tx_buf[2+i];
        end
        wr_txn(DEV, len + 2, ok);
        chk(ok, "R5 random block acks", ok, 1);
        wr1(8'h00, 8'(len));
        rd_txn(8'(base) | 8'h80, 1'b1, len + 1);
        chk(rx_buf[0] == clamp32(mdl[0]), "R6 random count", rx_buf[0], len);
        for (int i = 0; i < len; i++) begin
          p = base + i;
          chk(rx_buf[1+i] == mdl[p], "R6 random data", rx_buf[1+i], mdl[p]);
        end
      end
    end

    // R8 / R9: stall with SCL low while the slave drives a 0 bit
    wr1(8'h05, 8'h12);
    bus_start(); send_byte({DEV, 1'b0}, ok); send_byte(8'h05, ok);
    bus_start(); send_byte({DEV, 1'b1}, ok);
    w(3*TO);
    chk(sda_line == 1'b0, "R8 timeout off after reset", sda_line, 0);
    recv_byte(1'b1, b);
    chk(b == 8'h12, "R8 transfer continues", b, 8'h12);
    bus_stop();

    wr1(8'h01, 8'h10);
    bus_start(); send_byte({DEV, 1'b1}, ok);
    w(3*TO);
    chk(sda_line == 1'b1, "R9 scl timeout releases", sda_line, 1);
    bus_stop();

    wr1(8'h01, 8'h20);
    bus_start(); send_byte({DEV, 1'b1}, ok);
    w(3*TO);
    chk(sda_line == 1'b1, "R9 sda timeout releases", sda_line, 1);
    bus_stop();
    wr1(8'h01, 8'h00);
    rd_txn(8'h05, 1'b1, 1);
    chk(rx_buf[0] == 8'h12, "R10 normal after timeout", rx_buf[0], 8'h12);

    summary();
  end
endmodule